// File: doc/BRIEF.md
# Serial Display-RAM Port

This block is a chip-select framed serial slave that gives a host with only general-purpose I/O pins access to a 192-nibble display memory. It has separate write and read strobes and one shared data line. All four pins are oversampled by the block's system clock. The two strobes are edge-detected in that clock domain, so no logic runs on the host's strobes as clocks.

Each frame opens with a three-bit mode code. A data frame follows it with an eight-bit address and then any number of four-bit nibbles, which go to or come from consecutive locations. A command frame follows it with nine-bit command words, back to back, and does not repeat the code. The write frame also serves a read-modify-write pattern: at a nibble boundary, a read-strobe burst reads out the current location first, and the address moves on only after the rewrite. Each decoded command leaves the block on a valid/ready port. The host cannot be paused, so that port holds one word. A word that completes while the previous word is still held and is not taken in that cycle is dropped.

The system clock must run at least four times faster than the strobe toggle rate.

Top module: `segram_serial_port`

## Requirements
- R1: The first three bits captured after chip select goes low select the frame type, first bit most significant: 110 is read, 101 is write (including read-modify-write), 100 is command. Any other code makes the rest of the frame have no effect until chip select goes high.
- R2: In a data frame the mode code is followed by an 8-bit address sent most significant bit first. Each nibble then travels least significant bit first.
- R3: A bit on the data pin is taken on each rising edge of the write strobe.
- R4: In a read frame, each falling edge of the read strobe places the next bit of the current nibble on the data output, starting with bit 0, for the host to sample on the next rising edge.
- R5: While chip select stays low, each completed nibble advances the address by one, in read and write frames alike.
- R6: In a write frame, a read-strobe burst of four pulses at a nibble boundary reads out the nibble at the current address without advancing it. The following four write-strobe bits rewrite that same address, and only then does the address advance.
- R7: A command frame carries 9-bit words, most significant first. Bits C8..C1 of each word are presented as the 8-bit command code and C0 is ignored. Further words follow under the same chip select without a new mode code.
- R8: Chip select high aborts any partial frame, releases the data output and returns to waiting for a mode code.
- R9: The memory holds 192 nibbles. Auto-increment from address 191 or above wraps to 0. Writes to addresses 192..255 change nothing, and reads there return 0.
- R10: The data output enable is high only in a read phase: in a read frame from the first read-strobe fall until chip select rises, and in a read-modify-write from the first read-strobe fall until the read-strobe rise after the fourth bit. It stays low during address, write and command phases.
- R11: `cmd_valid_o` stays high with `cmd_code_o` unchanged until `cmd_ready_i` is high on a clock edge. A word completing while one is held and not taken in that cycle is discarded.
- R12: After reset the memory reads as all zeros, the output enable is low and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, frames each transfer |
| wr_i | input | 1 | Write strobe; data taken on its rising edge |
| rd_i | input | 1 | Read strobe; next bit driven after its falling edge |
| data_i | input | 1 | Data pin as seen from the pad input |
| data_o | output | 1 | Data bit driven toward the pad |
| data_oe_o | output | 1 | Pad output enable for the data pin |
| cmd_valid_o | output | 1 | A decoded command word is held |
| cmd_ready_i | input | 1 | Consumer takes the held command word |
| cmd_code_o | output | 8 | Command bits C8..C1 |

## Verification
The hardest situation to reach is the read-modify-write turnaround. There the output enable must drop on the read-strobe rise after the fourth bit, the rewrite must land on the address just read, and the following read burst must come from the next address. The bench gets there with a directed write frame that interleaves four read pulses and four write pulses per nibble, and it checks the output enable between the two halves. Address wrap and ignored writes above 191 are reached by bursts that start near the top of the map. Dropped command words are reached by sending two words back to back while the ready input is held low.

// File: rtl/segser_pkg.sv
package segser_pkg;
  typedef enum logic [2:0] {
    PH_ID,
    PH_ADDR,
    PH_DATA,
    PH_CMD,
    PH_DEAD
  } phase_t;

  localparam int MODE_BITS = 3;
  localparam logic [MODE_BITS-1:0] MODE_READ  = 3'b110;
  localparam logic [MODE_BITS-1:0] MODE_WRITE = 3'b101;
  localparam logic [MODE_BITS-1:0] MODE_CMD   = 3'b100;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      lvl_o  <= RST_VAL;
    end else begin
      meta_q <= pin_i;
      lvl_o  <= meta_q;
    end
  end
endmodule

// File: rtl/nibble_ram.sv
module nibble_ram #(
  parameter int AW    = 8,
  parameter int DW    = 4,
  parameter int DEPTH = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && (waddr_i < TOP)) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i < TOP) ? mem[raddr_i] : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (waddr_i < TOP)) |=> (mem[$past(waddr_i)] == $past(wdata_i))); // R9
endmodule

// File: rtl/frame_decoder.sv
module frame_decoder
  import segser_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 4,
  parameter int DEPTH = 192,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s_i,
  input  logic          wr_s_i,
  input  logic          rd_s_i,
  input  logic          din_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          dout_o,
  output logic          oe_o,
  output logic          cstb_o,
  output logic [CW-2:0] ccode_o
);
  localparam int DIW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int MAXC = (AW > CW) ? AW : CW;
  localparam int CNTW = $clog2(MAXC + 1);
  localparam logic [AW-1:0]   LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [DIW-1:0]  LAST_BIT  = DIW'(DW - 1);
  localparam logic [CNTW-1:0] ID_END    = CNTW'(MODE_BITS - 1);
  localparam logic [CNTW-1:0] ADDR_END  = CNTW'(AW - 1);
  localparam logic [CNTW-1:0] NIB_END   = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] CMD_END   = CNTW'(CW - 1);

  phase_t         ph_q;
  logic           rd_mode_q;
  logic [CNTW-1:0] cnt_q;
  logic [1:0]     id_q;
  logic [AW-1:0]  addr_q;
  logic [DW-2:0]  wbuf_q;
  logic [DIW-1:0] rbit_q;
  logic           rlast_q;
  logic [CW-2:0]  csh_q;
  logic           wr_q, rd_q;

  logic wr_rise, rd_fall, rd_rise;
  logic [AW-1:0] addr_nxt;
  logic [MODE_BITS-1:0] id_full;

  assign wr_rise  = wr_s_i & ~wr_q;
  assign rd_fall  = ~rd_s_i & rd_q;
  assign rd_rise  = rd_s_i & ~rd_q;
  assign addr_nxt = (addr_q >= LAST_ADDR) ? '0 : addr_q + 1'b1;
  assign id_full  = {id_q, din_i};
  assign raddr_o  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_s_i;
      rd_q <= rd_s_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_ID;
      rd_mode_q <= 1'b0;
      cnt_q     <= '0;
      id_q      <= '0;
      addr_q    <= '0;
      wbuf_q    <= '0;
      rbit_q    <= '0;
      rlast_q   <= 1'b0;
      csh_q     <= '0;
      we_o      <= 1'b0;
      waddr_o   <= '0;
      wdata_o   <= '0;
      dout_o    <= 1'b0;
      oe_o      <= 1'b0;
      cstb_o    <= 1'b0;
      ccode_o   <= '0;
    end else begin
      we_o   <= 1'b0;
      cstb_o <= 1'b0;
      if (cs_s_i) begin
        ph_q    <= PH_ID;
        cnt_q   <= '0;
        oe_o    <= 1'b0;
        rbit_q  <= '0;
        rlast_q <= 1'b0;
      end else begin
        unique case (ph_q)
          PH_ID: if (wr_rise) begin
            id_q <= id_full[1:0];
            if (cnt_q == ID_END) begin
              cnt_q <= '0;
              rbit_q <= '0;
              case (id_full)
                MODE_READ:  begin ph_q <= PH_ADDR; rd_mode_q <= 1'b1; end
                MODE_WRITE: begin ph_q <= PH_ADDR; rd_mode_q <= 1'b0; end
                MODE_CMD:   ph_q <= PH_CMD;
                default:    ph_q <= PH_DEAD;
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_ADDR: if (wr_rise) begin
            addr_q <= {addr_q[AW-2:0], din_i};
            if (cnt_q == ADDR_END) begin
              cnt_q <= '0;
              ph_q  <= PH_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (rd_mode_q) begin
              if (rd_fall) begin
                dout_o <= rdata_i[rbit_q];
                oe_o   <= 1'b1;
                if (rbit_q == LAST_BIT) begin
                  rbit_q <= '0;
                  addr_q <= addr_nxt;
                end else begin
                  rbit_q <= rbit_q + 1'b1;
                end
              end
            end else if (wr_rise) begin
              oe_o    <= 1'b0;
              rlast_q <= 1'b0;
              rbit_q  <= '0;
              if (cnt_q == NIB_END) begin
                we_o    <= 1'b1;
                waddr_o <= addr_q;
                wdata_o <= {din_i, wbuf_q};
                addr_q  <= addr_nxt;
                cnt_q   <= '0;
              end else begin
                wbuf_q[cnt_q[DIW-1:0]] <= din_i;
                cnt_q <= cnt_q + 1'b1;
              end
            end else if (rd_fall && (cnt_q == '0)) begin
              dout_o <= rdata_i[rbit_q];
              oe_o   <= 1'b1;
              if (rbit_q == LAST_BIT) begin
                rbit_q  <= '0;
                rlast_q <= 1'b1;
              end else begin
                rbit_q <= rbit_q + 1'b1;
              end
            end else if (rd_rise && rlast_q) begin
              oe_o    <= 1'b0;
              rlast_q <= 1'b0;
            end
          end
          PH_CMD: if (wr_rise) begin
            if (cnt_q == CMD_END) begin
              cstb_o  <= 1'b1;
              ccode_o <= csh_q;
              cnt_q   <= '0;
            end else begin
              csh_q <= {csh_q[CW-3:0], din_i};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_DROPS_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s_i |=> !oe_o); // R8
  AST_NO_OE_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cstb_o |-> !oe_o); // R10
  AST_ADDR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (addr_q <= LAST_ADDR)); // R9
endmodule

// File: rtl/cmd_hold.sv
module cmd_hold #(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic [OW-1:0] code_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [OW-1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else if (stb_i && (!valid_o || ready_i)) begin
      valid_o <= 1'b1;
      code_o  <= code_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(code_o))); // R11
endmodule

// File: rtl/segram_serial_port.sv
module segram_serial_port #(
  parameter int ADDR_BITS = 8,
  parameter int NIB_BITS  = 4,
  parameter int RAM_DEPTH = 192,
  parameter int CMD_BITS  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic                data_i,
  output logic                data_o,
  output logic                data_oe_o,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic [CMD_BITS-2:0] cmd_code_o
);
  localparam int PINS = 4;

  logic [PINS-1:0] pins_s;
  logic [ADDR_BITS-1:0] raddr, waddr;
  logic [NIB_BITS-1:0]  rdata, wdata;
  logic                 we, cstb;
  logic [CMD_BITS-2:0]  ccode;

  pin_sync #(.W(PINS), .RST_VAL({PINS{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({cs_n_i, wr_i, rd_i, data_i}),
    .lvl_o (pins_s)
  );

  frame_decoder #(
    .AW(ADDR_BITS), .DW(NIB_BITS), .DEPTH(RAM_DEPTH), .CW(CMD_BITS)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s_i  (pins_s[3]),
    .wr_s_i  (pins_s[2]),
    .rd_s_i  (pins_s[1]),
    .din_i   (pins_s[0]),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .dout_o  (data_o),
    .oe_o    (data_oe_o),
    .cstb_o  (cstb),
    .ccode_o (ccode)
  );

  nibble_ram #(.AW(ADDR_BITS), .DW(NIB_BITS), .DEPTH(RAM_DEPTH)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  cmd_hold #(.OW(CMD_BITS - 1)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_i   (cstb),
    .code_i  (ccode),
    .ready_i (cmd_ready_i),
    .valid_o (cmd_valid_o),
    .code_o  (cmd_code_o)
  );
endmodule

// File: tb/tb_segram_serial_port.sv
module tb_segram_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int H = 5;
  localparam int DEPTH = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr = 1'b1, rd = 1'b1, din = 1'b1, ready = 1'b0;
  logic dout, oe, cvalid;
  logic [7:0] ccode;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  segram_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_i(wr), .rd_i(rd),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .cmd_valid_o(cvalid),
    .cmd_ready_i(ready), .cmd_code_o(ccode)
  );

  function automatic logic [7:0] nxt(logic [7:0] a);
    return (a >= 8'(DEPTH - 1)) ? 8'd0 : a + 8'd1;
  endfunction

  function automatic logic [3:0] mrd(logic [7:0] a);
    return (a < 8'(DEPTH)) ? model[a] : 4'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_bit(logic b);
    din = b; wr = 1'b0; tick(H); wr = 1'b1; tick(H);
  endtask

  task automatic rd_bit(output logic b, output logic e);
    rd = 1'b0; tick(H); b = dout; e = oe; rd = 1'b1; tick(H);
  endtask

  task automatic open_frame(logic [2:0] id);
    cs_n = 1'b0; tick(H);
    for (int i = 2; i >= 0; i--) wr_bit(id[i]);
  endtask

  task automatic close_frame();
    cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic send_addr(logic [7:0] a);
    for (int i = 7; i >= 0; i--) wr_bit(a[i]);
  endtask

  task automatic send_nib(logic [3:0] v);
    for (int i = 0; i < 4; i++) wr_bit(v[i]);
  endtask

  task automatic get_nib(output logic [3:0] v, output logic e_all);
    logic b, e;
    e_all = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_bit(b, e);
      v[i] = b;
      e_all = e_all & e;
    end
  endtask

  task automatic write_burst(logic [7:0] a, int n);
    logic [7:0] aa = a;
    logic [3:0] v;
    open_frame(3'b101);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      v = 4'($urandom);
      send_nib(v);
      if (aa < 8'(DEPTH)) model[aa] = v;
      aa = nxt(aa);
    end
    check("R10 oe low while writing", 32'(oe), 32'd0);
    close_frame();
  endtask

  task automatic read_burst(logic [7:0] a, int n, string req);
    logic [7:0] aa = a;
    logic [3:0] v;
    logic e;
    open_frame(3'b110);
    send_addr(a);
    check("R10 oe low before read strobe", 32'(oe), 32'd0);
    for (int i = 0; i < n; i++) begin
      get_nib(v, e);
      check(req, 32'(v), 32'(mrd(aa)));
      check("R4 oe during read bits", 32'(e), 32'd1);
      aa = nxt(aa);
    end
    close_frame();
    check("R8 oe released after cs high", 32'(oe), 32'd0);
  endtask

  task automatic pulse_ready();
    ready = 1'b1; tick(1); ready = 1'b0; tick(1);
  endtask

  task automatic send_word(logic [8:0] w);
    for (int i = 8; i >= 0; i--) wr_bit(w[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] v, old;
    logic e, b;
    logic [8:0] w1, w2, w3, w4;
    void'($urandom(32'd7731));
    for (int i = 0; i < DEPTH; i++) model[i] = 4'd0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R12 reset state
    check("R12 oe after reset", 32'(oe), 32'd0);
    check("R12 cmd_valid after reset", 32'(cvalid), 32'd0);
    read_burst(8'd0, 3, "R12 memory zero");

    // R2 R3: single nibble, asymmetric pattern shows bit order
    open_frame(3'b101); send_addr(8'h2A); send_nib(4'b0001); close_frame();
    model[8'h2A] = 4'b0001;
    read_burst(8'h2A, 1, "R2 R3 single nibble");
    read_burst(8'h54, 1, "R2 address order (reversed addr untouched)");

    // R5 R9 wrap across top
    write_burst(8'd189, 5);
    read_burst(8'd189, 5, "R5 successive read across wrap");
    read_burst(8'd0, 2, "R9 wrap landed at 0");

    // R9 write to out-of-range address
    open_frame(3'b101); send_addr(8'd200); send_nib(4'hF); send_nib(4'h9); close_frame();
    model[0] = 4'h9;
    read_burst(8'd200, 1, "R9 read above depth is zero");
    read_burst(8'd0, 1, "R9 auto-increment from 200 wraps to 0");

    // R6 read-modify-write
    model[50] = 4'h3; model[51] = 4'hC; model[52] = 4'h6;
    open_frame(3'b101); send_addr(8'd50);
    send_nib(4'h3); send_nib(4'hC); send_nib(4'h6); close_frame();
    open_frame(3'b101); send_addr(8'd50);
    for (int k = 0; k < 3; k++) begin
      get_nib(old, e);
      check("R6 rmw read nibble", 32'(old), 32'(model[50 + k]));
      check("R10 oe during rmw read", 32'(e), 32'd1);
      check("R10 oe low after rmw read", 32'(oe), 32'd0);
      send_nib(~old);
      model[50 + k] = ~old;
    end
    close_frame();
    read_burst(8'd50, 3, "R6 rmw rewrite result");

    // R7 R11 commands
    w1 = 9'h1A5; w2 = 9'h0F2; w3 = 9'h133; w4 = 9'h0C8;
    open_frame(3'b100);
    send_word(w1);
    check("R7 first cmd valid", 32'(cvalid), 32'd1);
    check("R7 first cmd code", 32'(ccode), 32'(w1[8:1]));
    check("R10 oe low in command frame", 32'(oe), 32'd0);
    pulse_ready();
    check("R11 valid drops after ready", 32'(cvalid), 32'd0);
    send_word(w2);
    check("R7 second cmd code without id", 32'(ccode), 32'(w2[8:1]));
    pulse_ready();
    send_word(w3);
    send_word(w4);
    check("R11 held word kept", 32'(ccode), 32'(w3[8:1]));
    check("R11 held valid", 32'(cvalid), 32'd1);
    pulse_ready();
    check("R11 later word dropped", 32'(cvalid), 32'd0);
    close_frame();

    // R8 abort mid-address, then mid-read
    open_frame(3'b101); wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1); close_frame();
    open_frame(3'b101); send_addr(8'd7); send_nib(4'h5); close_frame();
    model[7] = 4'h5;
    read_burst(8'd7, 1, "R8 frame after abort");
    open_frame(3'b110); send_addr(8'd7); rd_bit(b, e);
    check("R8 oe mid read", 32'(e), 32'd1);
    close_frame();
    check("R8 oe after abort in read", 32'(oe), 32'd0);

    // R1 invalid mode code ignored
    open_frame(3'b111); send_addr(8'd3); send_nib(4'hA); send_word(9'h1FF); close_frame();
    check("R1 no command from bad id", 32'(cvalid), 32'd0);
    read_burst(8'd3, 1, "R1 bad id leaves memory");
    open_frame(3'b110); send_addr(8'd3);
    for (int i = 0; i < 4; i++) wr_bit(1'b1);
    close_frame();
    read_burst(8'd3, 1, "R4 write strobes ignored in read frame");

    // Random bursts
    for (int it = 0; it < 25; it++) begin
      logic [7:0] a = 8'($urandom_range(0, DEPTH - 1));
      int n = $urandom_range(1, 6);
      write_burst(a, n);
      read_burst(a, n, "R5 random burst readback");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule